// File: doc/BRIEF.md
# Identification Read Mode and Boot Region Lockout

This block sits beside the array of a byte-wide flash memory and does two jobs. It watches the stream of byte-load writes for short command sequences. One sequence switches the part into an identification read mode and another switches it back out. While that mode is active, a handful of read addresses return fixed codes and lockout status bytes in place of array contents. Every other address still returns array data.

The block also keeps two write-once lockout flags. One covers the lowest 8 KB of the address space and the other covers the highest 8 KB. A seven-write sequence sets one of them, and the address of the last write picks which. Program requests that target a locked region are refused. A whole-chip erase is refused as soon as either region is locked.

Identification mode can also be forced by a digital flag. That flag stands in for the high-voltage level on address pin 9 in the hardware entry method. The codes returned are the same in both cases.

The write port carries single-cycle byte-load strobes that have already been latched and filtered upstream. It has no ready signal and every strobe is consumed in its own cycle, so it never applies back-pressure. The read path, the program check and the erase check are combinational lookups with no handshake.

Top module: `idlk_top`

## Requirements
- R1: After `rst_n` is released, identification mode is off and both regions read as unlocked.
- R2: The write sequence 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x90 (address/data) turns software identification mode on in the cycle after its third write. The same sequence with 0xF0 as the third byte turns it off.
- R3: While `hv_id` is high, identification reads are active whatever the software mode is. Both entry methods return the same codes.
- R4: In identification mode, address 0x00000 returns 0x1F and address 0x00001 returns 0xD5. Every address not listed in R4 or R5, and every read made outside identification mode, returns `arr_data` unchanged.
- R5: In identification mode, address 0x00002 reports the lower region and address 0x1E002 reports the upper region. The status byte is 0xFE when the region is programmable and 0xFF when it is locked.
- R6: The lockout sequence is seven writes: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x60, then data 0x40 at any address. The final address selects the region: below 0x02000 locks the lower region, and 0x1E000 or above locks the upper region. Any other final address locks nothing.
- R7: A write that does not match the next expected step abandons the sequence in progress and changes no state. If that write is 0x5555/0xAA, it counts as a fresh first step.
- R8: A lockout flag, once set, stays set until `rst_n` is asserted, which is the only way to clear it.
- R9: `prog_ok` equals `prog_req`, except that it is low when `prog_addr` lies in a locked region.
- R10: `erase_ok` equals `erase_req` while both regions are unlocked, and is low whenever either region is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (test only; also clears lockout) |
| wr_en | input | 1 | One-cycle byte-load strobe |
| wr_addr | input | 17 | Byte-load address |
| wr_data | input | 8 | Byte-load data |
| hv_id | input | 1 | Hardware identification request (high-voltage level on pin 9) |
| rd_addr | input | 17 | Read address |
| arr_data | input | 8 | Data read from the array at `rd_addr` |
| rd_data | output | 8 | Read data after identification substitution |
| id_active | output | 1 | Identification reads are in effect |
| prog_req | input | 1 | Request to program the sector holding `prog_addr` |
| prog_addr | input | 17 | Target address of the program request |
| prog_ok | output | 1 | Program request allowed |
| erase_req | input | 1 | Whole-chip erase request |
| erase_ok | output | 1 | Chip erase allowed |

## Verification
The embedded properties assume that all inputs are steady around the rising clock edge. They also assume that `wr_en` marks exactly one cycle for each byte load, so a strobe held high would count as repeated writes. The bench changes every input only on falling edges and pulses `wr_en` for a single cycle. Its random write noise avoids the two command addresses so that it cannot assemble a sequence by chance, while the directed cases cover deliberately broken and misaddressed sequences.

// File: rtl/idlk_pkg.sv
package idlk_pkg;
  localparam logic [7:0] CMD_B1     = 8'hAA;
  localparam logic [7:0] CMD_B2     = 8'h55;
  localparam logic [7:0] CMD_ENTER  = 8'h90;
  localparam logic [7:0] CMD_LEAVE  = 8'hF0;
  localparam logic [7:0] CMD_LOCK   = 8'h80;
  localparam logic [7:0] CMD_LOCK6  = 8'h60;
  localparam logic [7:0] CMD_LOCK7  = 8'h40;
  localparam logic [7:0] STAT_OPEN  = 8'hFE;
  localparam logic [7:0] STAT_SHUT  = 8'hFF;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_GOT1, SQ_GOT2, SQ_LK3, SQ_LK4, SQ_LK5, SQ_LK6
  } seq_step_t;

  typedef struct packed {
    logic lo;
    logic hi;
  } lock_pair_t;
endpackage

// File: rtl/idlk_cmd_seq.sv
module idlk_cmd_seq
  import idlk_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              sw_id,
  output logic              lock_fire
);
  localparam logic [ADDR_W-1:0] ADR_P = ADDR_W'(32'h5555);
  localparam logic [ADDR_W-1:0] ADR_Q = ADDR_W'(32'h2AAA);

  seq_step_t step_q, step_d;
  logic      id_q, id_d;
  logic      at_p, at_q, fresh;

  assign at_p  = (wr_addr == ADR_P);
  assign at_q  = (wr_addr == ADR_Q);
  assign fresh = at_p && (wr_data == CMD_B1);

  always_comb begin
    step_d    = step_q;
    id_d      = id_q;
    lock_fire = 1'b0;
    if (wr_en) begin
      step_d = fresh ? SQ_GOT1 : SQ_IDLE;
      unique case (step_q)
        SQ_IDLE: ;
        SQ_GOT1: if (at_q && wr_data == CMD_B2) step_d = SQ_GOT2;
        SQ_GOT2: begin
          if (at_p && wr_data == CMD_ENTER) begin
            id_d = 1'b1; step_d = SQ_IDLE;
          end else if (at_p && wr_data == CMD_LEAVE) begin
            id_d = 1'b0; step_d = SQ_IDLE;
          end else if (at_p && wr_data == CMD_LOCK) begin
            step_d = SQ_LK3;
          end
        end
        SQ_LK3: if (fresh) step_d = SQ_LK4;
        SQ_LK4: if (at_q && wr_data == CMD_B2) step_d = SQ_LK5;
        SQ_LK5: if (at_p && wr_data == CMD_LOCK6) step_d = SQ_LK6;
        SQ_LK6: if (wr_data == CMD_LOCK7) begin
          lock_fire = 1'b1; step_d = SQ_IDLE;
        end
        default: step_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= SQ_IDLE;
      id_q   <= 1'b0;
    end else begin
      step_q <= step_d;
      id_q   <= id_d;
    end
  end

  assign sw_id = id_q;

  // R7
  step_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_q inside {SQ_IDLE, SQ_GOT1, SQ_GOT2, SQ_LK3, SQ_LK4, SQ_LK5, SQ_LK6});

  // R2
  id_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(id_q));
endmodule

// File: rtl/idlk_lock_regs.sv
module idlk_lock_regs
  import idlk_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BOOT_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] prog_addr,
  output lock_pair_t        locks,
  output logic              prog_blocked
);
  localparam int TAG_W = ADDR_W - BOOT_W;

  lock_pair_t lk_q;
  logic wr_lo, wr_hi, pg_lo, pg_hi;

  assign wr_lo = (wr_addr[ADDR_W-1:BOOT_W] == '0);
  assign wr_hi = (wr_addr[ADDR_W-1:BOOT_W] == {TAG_W{1'b1}});
  assign pg_lo = (prog_addr[ADDR_W-1:BOOT_W] == '0);
  assign pg_hi = (prog_addr[ADDR_W-1:BOOT_W] == {TAG_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_q <= '0;
    end else if (lock_fire) begin
      if (wr_lo) lk_q.lo <= 1'b1;
      if (wr_hi) lk_q.hi <= 1'b1;
    end
  end

  assign locks        = lk_q;
  assign prog_blocked = (pg_lo && lk_q.lo) || (pg_hi && lk_q.hi);

  // R8
  lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_q.lo |=> lk_q.lo);
  // R8
  hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_q.hi |=> lk_q.hi);
endmodule

// File: rtl/idlk_read_mux.sv
module idlk_read_mux
  import idlk_pkg::*;
#(
  parameter int         ADDR_W   = 17,
  parameter int         BOOT_W   = 13,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'hD5
) (
  input  logic              id_on,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_data,
  input  lock_pair_t        locks,
  output logic [7:0]        rd_data
);
  localparam logic [ADDR_W-1:0] A_MFR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DEV  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LOST = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HIST =
    {{(ADDR_W-BOOT_W){1'b1}}, BOOT_W'(2)};

  always_comb begin
    rd_data = arr_data;
    if (id_on) begin
      if (rd_addr == A_MFR)       rd_data = MFR_CODE;
      else if (rd_addr == A_DEV)  rd_data = DEV_CODE;
      else if (rd_addr == A_LOST) rd_data = locks.lo ? STAT_SHUT : STAT_OPEN;
      else if (rd_addr == A_HIST) rd_data = locks.hi ? STAT_SHUT : STAT_OPEN;
    end
  end
endmodule

// File: rtl/idlk_top.sv
module idlk_top
  import idlk_pkg::*;
#(
  parameter int         ADDR_W   = 17,
  parameter int         BOOT_W   = 13,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              hv_id,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_data,
  output logic [7:0]        rd_data,
  output logic              id_active,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  output logic              prog_ok,
  input  logic              erase_req,
  output logic              erase_ok
);
  logic       sw_id, lock_fire, prog_blocked;
  lock_pair_t locks;

  idlk_cmd_seq #(.ADDR_W(ADDR_W)) seq_u (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sw_id(sw_id), .lock_fire(lock_fire)
  );

  idlk_lock_regs #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) lock_u (
    .clk(clk), .rst_n(rst_n), .lock_fire(lock_fire), .wr_addr(wr_addr),
    .prog_addr(prog_addr), .locks(locks), .prog_blocked(prog_blocked)
  );

  assign id_active = sw_id | hv_id;

  idlk_read_mux #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W),
                  .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) rmux_u (
    .id_on(id_active), .rd_addr(rd_addr), .arr_data(arr_data),
    .locks(locks), .rd_data(rd_data)
  );

  assign prog_ok  = prog_req & ~prog_blocked;
  assign erase_ok = erase_req & ~(locks.lo | locks.hi);

  // R10
  erase_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locks.lo || locks.hi) |-> !erase_ok);
  // R9
  prog_lo_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && locks.lo && prog_addr[ADDR_W-1:BOOT_W] == '0) |-> !prog_ok);
  // R9
  prog_hi_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && locks.hi && (&prog_addr[ADDR_W-1:BOOT_W])) |-> !prog_ok);
  // R4
  mfr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_active && rd_addr == '0) |-> rd_data == MFR_CODE);
  // R3
  hv_forces_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hv_id |-> id_active);
  // R2
  enter_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_id) |-> $past(wr_en));
  // R6
  lock_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locks.lo) || $rose(locks.hi)) |-> $past(wr_en));
endmodule

// File: tb/idlk_top_tb_top.sv
module idlk_top_tb_top;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          hv_id = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    arr_data = '0;
  logic [7:0]    rd_data;
  logic          id_active;
  logic          prog_req = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic          prog_ok;
  logic          erase_req = 1'b0;
  logic          erase_ok;

  int total = 0;
  int bad   = 0;
  bit m_id = 0, m_lo = 0, m_hi = 0;

  always #5 clk = ~clk;

  idlk_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hv_id(hv_id), .rd_addr(rd_addr),
    .arr_data(arr_data), .rd_data(rd_data), .id_active(id_active),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_ok(prog_ok),
    .erase_req(erase_req), .erase_ok(erase_ok)
  );

  function automatic logic [7:0] exp_rd(bit idm, logic [AW-1:0] a,
                                        logic [7:0] arr, bit lo, bit hi);
    if (!idm) return arr;
    if (a == 17'h00000) return 8'h1F;
    if (a == 17'h00001) return 8'hD5;
    if (a == 17'h00002) return lo ? 8'hFF : 8'hFE;
    if (a == 17'h1E002) return hi ? 8'hFF : 8'hFE;
    return arr;
  endfunction

  function automatic bit exp_prog(logic [AW-1:0] a, bit lo, bit hi);
    if (a < 17'h02000 && lo) return 1'b0;
    if (a >= 17'h1E000 && hi) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a);
    @(negedge clk);
    rd_addr = a; arr_data = 8'($urandom);
    #2;
    chk(req, rd_data, exp_rd(m_id | hv_id, a, arr_data, m_lo, m_hi));
  endtask

  task automatic pe_chk(string req, logic [AW-1:0] a);
    @(negedge clk);
    prog_req = 1'b1; prog_addr = a; erase_req = 1'b1;
    #2;
    chk(req, prog_ok, exp_prog(a, m_lo, m_hi));
    chk("R10", erase_ok, !(m_lo || m_hi));
    prog_req = 1'b0; erase_req = 1'b0;
  endtask

  task automatic lock_seq(logic [AW-1:0] fin, logic [7:0] d6);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, d6);
    wr(fin, 8'h40);
  endtask

  task automatic rand_phase(int n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      int sel = $urandom_range(0, 5);
      case (sel)
        0: a = 17'h00000;
        1: a = 17'h00001;
        2: a = 17'h00002;
        3: a = 17'h1E002;
        default: a = AW'($urandom);
      endcase
      if ($urandom_range(0, 3) == 0) begin
        logic [AW-1:0] w = AW'($urandom);
        if (w == 17'h05555 || w == 17'h02AAA) w = w ^ 17'h00100;
        wr(w, 8'($urandom));
      end
      hv_id = ($urandom_range(0, 3) == 0);
      rd_chk("R4/R5 random read", a);
      pe_chk("R9 random program", AW'($urandom));
    end
    hv_id = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 id_active", id_active, 1'b0);
    rd_chk("R1 read", 17'h00002);
    pe_chk("R1 program low", 17'h00010);
    // R3 hardware entry
    hv_id = 1'b1;
    rd_chk("R3 mfr", 17'h00000);
    rd_chk("R3 dev", 17'h00001);
    rd_chk("R5 lower open", 17'h00002);
    rd_chk("R5 upper open", 17'h1E002);
    rd_chk("R4 other addr", 17'h00003);
    hv_id = 1'b0;
    rd_chk("R4 no id", 17'h00001);
    // R2 software entry and exit
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h90);
    m_id = 1;
    #2 chk("R2 entered", id_active, 1'b1);
    rd_chk("R2 mfr", 17'h00000);
    rd_chk("R2 dev", 17'h00001);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hF0);
    m_id = 0;
    #2 chk("R2 left", id_active, 1'b0);
    rd_chk("R2 after exit", 17'h00000);
    // R7 broken sequences
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h12);
    #2 chk("R7 bad third", id_active, 1'b0);
    wr(17'h05555, 8'hAA); wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'h90);
    m_id = 1;
    #2 chk("R7 restart on AA", id_active, 1'b1);
    lock_seq(17'h00100, 8'h61);
    rd_chk("R7 lock step6 wrong", 17'h00002);
    rand_phase(60);
    // R6 lock lower
    lock_seq(17'h00100, 8'h60);
    m_lo = 1;
    rd_chk("R6 lower locked", 17'h00002);
    rd_chk("R5 upper still open", 17'h1E002);
    pe_chk("R9 low refused", 17'h01FFF);
    pe_chk("R9 mid allowed", 17'h08000);
    pe_chk("R9 high allowed", 17'h1E000);
    // R6 middle final address locks nothing
    lock_seq(17'h04000, 8'h60);
    rd_chk("R6 mid none", 17'h1E002);
    rand_phase(60);
    // R6 lock upper
    lock_seq(17'h1FFFF, 8'h60);
    m_hi = 1;
    rd_chk("R6 upper locked", 17'h1E002);
    pe_chk("R9 top refused", 17'h1E000);
    pe_chk("R9 just below top", 17'h1DFFF);
    // R8 exit id then re-enter: flags kept
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hF0);
    m_id = 0;
    hv_id = 1'b1;
    rd_chk("R8 lower kept", 17'h00002);
    rd_chk("R8 upper kept", 17'h1E002);
    hv_id = 1'b0;
    rand_phase(60);
    // R8 test reset clears
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_lo = 0; m_hi = 0; m_id = 0;
    hv_id = 1'b1;
    rd_chk("R8 cleared lower", 17'h00002);
    rd_chk("R8 cleared upper", 17'h1E002);
    hv_id = 1'b0;
    pe_chk("R8 erase back", 17'h00000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule